// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A memory-mapped watchdog that counts down from a programmable 10-bit start value. Each tick from an internal prescaler lowers the count by one. A tick that arrives while the count is zero is an expiry. The first expiry raises a warning flag, reloads the count and arms a second stage. A second expiry without a reload in between raises a second flag and issues a one-cycle reset request. A sticky no-reboot bit can suppress that request.

Software keeps the timer alive by writing a key value to the counter register. It chooses the start value through a separate register and clears the flags by writing ones to them. A mode input selects the tick period. In the legacy period a tick is the equivalent of 0.6 s, and in the newer period it is 1 s. A lock input lets platform logic pin the no-reboot bit at one, and software can detect this because a clear attempt reads back as set.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the counter and the start value both read INIT_RST, the status and control words read zero, and rst_req_o is low.
- R2: While enabled, the counter decreases by one every DIV_NEW clock cycles when tick_mode_i is 1 and every DIV_LEGACY cycles when it is 0. The first tick comes that many cycles after the counter is loaded.
- R3: A write to word address 1 replaces bits [9:0] of the start value under byte enables (lane 0 covers bits 7:0, lane 1 covers bits 9:8). Bits [31:10] read as zero, and writing the start value does not load the counter.
- R4: A start-value write whose merged 10-bit result is 0, 1, 2 or 3 is ignored, and the previous value is kept.
- R5: A write to word address 0 with lane 0 enabled and data bits [7:0] equal to 0x01 loads the counter with the start value and returns the timer to the first stage. Any other value written there has no effect.
- R6: Reading word address 0 returns the live counter in bits [9:0], with zeros above.
- R7: An expiry in the first stage sets status bit 3, reloads the counter from the start value and moves the timer to the second stage.
- R8: An expiry in the second stage sets status bit 17, reloads the counter and returns the timer to the first stage. When the no-reboot bit is clear, it also drives rst_req_o high for exactly one cycle, on the cycle after the expiring tick.
- R9: The status bits at word address 2 are cleared by writing one to them (bit 3 through lane 0, bit 17 through lane 2). Writing 0x20008 with all lanes enabled clears both at once, and writing zeros leaves them unchanged.
- R10: Bit 4 of the control word at address 3 is the no-reboot bit, written through lane 0. While it is set, a second-stage expiry still sets bit 17 but rst_req_o stays low.
- R11: While nr_lock_i is high, the no-reboot bit is forced to one, and a write that clears it reads back as 1.
- R12: Bit 0 of the control word enables counting. While it is clear, the counter holds its value. Writing it from 0 to 1 loads the counter from the start value.
- R13: When a key write to address 0 falls in the same cycle as an expiring tick, the reload wins. No status bit is set and the counter reads the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word address (0 counter/key, 1 start value, 2 status, 3 control) |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte-lane write enables |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| tick_mode_i | input | 1 | Tick period select: 1 new period, 0 legacy period |
| nr_lock_i | input | 1 | Forces the no-reboot bit to stay set |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The keep-alive reload and an expiring tick can arrive in the same clock cycle. This is the one place where two functions contend for the counter and the stage. The bench first reloads the timer, then polls the counter as it steps from 1 to 0. It then places the key write so that the write lands exactly on the prescaler edge that would expire the timer. The result is judged by the status word staying clear and the counter reading the start value. A behavioural model, compared on every clock, also follows the flag and reset-pulse timing through both tick periods, the no-reboot gating and the lock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CNT_W    = 10;
  localparam int unsigned MIN_INIT = 4;
  localparam int unsigned STS1_BIT = 3;
  localparam int unsigned STS2_BIT = 17;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned NR_BIT   = 4;
  localparam logic [7:0]  RELOAD_KEY = 8'h01;

  typedef enum logic [1:0] {
    A_COUNT = 2'd0,
    A_INIT  = 2'd1,
    A_STAT  = 2'd2,
    A_CTRL  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned DIV_LEGACY = 30_000_000,
  parameter int unsigned DIV_NEW    = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic mode_i,
  output logic tick_o
);
  localparam int unsigned DIV_MAX = (DIV_LEGACY > DIV_NEW) ? DIV_LEGACY : DIV_NEW;
  localparam int unsigned PW      = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;
  localparam logic [PW-1:0] LIM_L = PW'(DIV_LEGACY - 1);
  localparam logic [PW-1:0] LIM_N = PW'(DIV_NEW - 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;
  logic          wrap;

  generate
    if (DIV_LEGACY == DIV_NEW) begin : g_single
      logic unused_mode;
      assign unused_mode = mode_i;
      assign lim = LIM_L;
    end else begin : g_dual
      assign lim = mode_i ? LIM_N : LIM_L;
    end
  endgenerate

  assign wrap   = (pre_q >= lim);
  assign tick_o = run_i && !restart_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pre_q <= '0;
    else if (restart_i || !run_i) pre_q <= '0;
    else if (wrap)                pre_q <= '0;
    else                          pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs import wdog_pkg::*; #(
  parameter logic [CNT_W-1:0] INIT_RST = 10'd60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [3:0]        be_i,
  input  logic              nr_lock_i,
  input  logic              exp1_i,
  input  logic              exp2_i,
  output logic [CNT_W-1:0]  init_o,
  output logic              en_o,
  output logic              nr_o,
  output logic              sts1_o,
  output logic              sts2_o,
  output logic              load_o
);
  logic [CNT_W-1:0] init_q, init_new;
  logic en_q, nr_q, sts1_q, sts2_q;
  logic wr_cnt, wr_init, wr_stat, wr_ctl;
  logic reload_hit, start_hit;
  logic unused_bits;

  assign wr_cnt  = wr_en_i && (addr_i == A_COUNT);
  assign wr_init = wr_en_i && (addr_i == A_INIT);
  assign wr_stat = wr_en_i && (addr_i == A_STAT);
  assign wr_ctl  = wr_en_i && (addr_i == A_CTRL) && be_i[0];

  assign reload_hit = wr_cnt && be_i[0] && (wdata_i[7:0] == RELOAD_KEY);
  assign start_hit  = wr_ctl && wdata_i[EN_BIT] && !en_q;
  assign load_o     = reload_hit || start_hit;

  // per-bit byte-lane merge of the start value
  for (genvar b = 0; b < CNT_W; b++) begin : g_merge
    assign init_new[b] = be_i[b/8] ? wdata_i[b] : init_q[b];
  end

  assign unused_bits = ^{wdata_i, be_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= INIT_RST;
      en_q   <= 1'b0;
      nr_q   <= 1'b0;
      sts1_q <= 1'b0;
      sts2_q <= 1'b0;
    end else begin
      if (wr_init && (init_new >= CNT_W'(MIN_INIT))) init_q <= init_new;
      if (wr_ctl) en_q <= wdata_i[EN_BIT];
      nr_q <= nr_lock_i | (wr_ctl ? wdata_i[NR_BIT] : nr_q);
      sts1_q <= exp1_i | (sts1_q & ~(wr_stat & be_i[0] & wdata_i[STS1_BIT]));
      sts2_q <= exp2_i | (sts2_q & ~(wr_stat & be_i[2] & wdata_i[STS2_BIT]));
    end
  end

  assign init_o = init_q;
  assign en_o   = en_q;
  assign nr_o   = nr_q;
  assign sts1_o = sts1_q;
  assign sts2_o = sts2_q;
endmodule

// File: rtl/wdog_core.sv
module wdog_core import wdog_pkg::*; #(
  parameter logic [CNT_W-1:0] INIT_RST = 10'd60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             nr_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             exp1_o,
  output logic             exp2_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic second_q, req_q, at_zero;

  assign at_zero = (cnt_q == '0);
  assign exp1_o  = tick_i && !load_i && at_zero && !second_q;
  assign exp2_o  = tick_i && !load_i && at_zero && second_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= INIT_RST;
      second_q <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      req_q <= exp2_o && !nr_i;
      if (load_i) begin
        cnt_q    <= init_i;
        second_q <= 1'b0;
      end else if (tick_i) begin
        if (at_zero) begin
          cnt_q    <= init_i;
          second_q <= !second_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage import wdog_pkg::*; #(
  parameter int unsigned      DIV_LEGACY = 30_000_000,
  parameter int unsigned      DIV_NEW    = 50_000_000,
  parameter logic [CNT_W-1:0] INIT_RST   = 10'd60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [3:0]        be_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_mode_i,
  input  logic              nr_lock_i,
  output logic              rst_req_o
);
  logic [CNT_W-1:0] init_w, cnt_w;
  logic en_w, nr_w, sts1_w, sts2_w, load_w, tick_w, exp1_w, exp2_w;

  wdog_regs #(.INIT_RST(INIT_RST)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .be_i, .nr_lock_i,
    .exp1_i (exp1_w),
    .exp2_i (exp2_w),
    .init_o (init_w),
    .en_o   (en_w),
    .nr_o   (nr_w),
    .sts1_o (sts1_w),
    .sts2_o (sts2_w),
    .load_o (load_w)
  );

  wdog_prescaler #(.DIV_LEGACY(DIV_LEGACY), .DIV_NEW(DIV_NEW)) u_pre (
    .clk_i, .rst_ni,
    .run_i     (en_w),
    .restart_i (load_w),
    .mode_i    (tick_mode_i),
    .tick_o    (tick_w)
  );

  wdog_core #(.INIT_RST(INIT_RST)) u_core (
    .clk_i, .rst_ni,
    .tick_i    (tick_w),
    .load_i    (load_w),
    .nr_i      (nr_w),
    .init_i    (init_w),
    .cnt_o     (cnt_w),
    .exp1_o    (exp1_w),
    .exp2_o    (exp2_w),
    .rst_req_o (rst_req_o)
  );

  always_comb begin
    rdata_o = '0;
    case (reg_addr_e'(addr_i))
      A_COUNT: rdata_o[CNT_W-1:0] = cnt_w;
      A_INIT:  rdata_o[CNT_W-1:0] = init_w;
      A_STAT: begin
        rdata_o[STS1_BIT] = sts1_w;
        rdata_o[STS2_BIT] = sts2_w;
      end
      A_CTRL: begin
        rdata_o[EN_BIT] = en_w;
        rdata_o[NR_BIT] = nr_w;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker import wdog_pkg::*; (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             nr_lock_i,
  input logic             rst_req_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] init_i,
  input logic             en_i,
  input logic             nr_i,
  input logic             load_i,
  input logic             exp1_i,
  input logic             exp2_i,
  input logic             sts1_i
);
  assert_init_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i >= CNT_W'(MIN_INIT));
  assert_load_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_i == $past(init_i)));
  assert_first_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp1_i |=> sts1_i);
  assert_req_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exp2_i && !nr_i) |=> rst_req_o);
  assert_req_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  assert_nr_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !$past(nr_i));
  assert_lock_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nr_lock_i |=> nr_i);
  assert_halt_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_i));
endmodule

bind wdog_two_stage wdog_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .nr_lock_i (nr_lock_i),
  .rst_req_o (rst_req_o),
  .cnt_i     (cnt_w),
  .init_i    (init_w),
  .en_i      (en_w),
  .nr_i      (nr_w),
  .load_i    (load_w),
  .exp1_i    (exp1_w),
  .exp2_i    (exp2_w),
  .sts1_i    (sts1_w)
);

// File: tb/wdog_two_stage_test.sv
module wdog_two_stage_test;
  localparam int unsigned DL = 3;
  localparam int unsigned DN = 5;
  localparam logic [9:0]  IR = 10'd8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  be_i = '0;
  logic        tick_mode_i = 1'b1;
  logic        nr_lock_i = 1'b0;
  logic [31:0] rdata_o;
  logic        rst_req_o;

  always #10 clk = ~clk;

  wdog_two_stage #(.DIV_LEGACY(DL), .DIV_NEW(DN), .INIT_RST(IR)) uut (
    .clk_i(clk), .rst_ni, .wr_en_i, .addr_i, .wdata_i, .be_i, .rdata_o,
    .tick_mode_i, .nr_lock_i, .rst_req_o
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  int m_pre, m_cnt, m_stage, m_init, m_en, m_nr, m_s1, m_s2, m_req, m_lim;
  bit m_rl, m_st, m_tk, m_e1, m_e2;
  logic [9:0] m_nv;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pre = 0; m_cnt = IR; m_stage = 0; m_init = IR; m_en = 0;
      m_nr = 0; m_s1 = 0; m_s2 = 0; m_req = 0;
    end else begin
      m_rl  = wr_en_i && addr_i == 2'd0 && be_i[0] && wdata_i[7:0] == 8'h01;
      m_st  = wr_en_i && addr_i == 2'd3 && be_i[0] && wdata_i[0] && m_en == 0;
      m_lim = tick_mode_i ? DN : DL;
      m_tk  = m_en != 0 && !(m_rl || m_st) && m_pre >= m_lim - 1;
      m_e1  = m_tk && m_cnt == 0 && m_stage == 0;
      m_e2  = m_tk && m_cnt == 0 && m_stage == 1;
      m_req = (m_e2 && m_nr == 0) ? 1 : 0;
      if (m_rl || m_st || m_en == 0 || m_pre >= m_lim - 1) m_pre = 0;
      else m_pre = m_pre + 1;
      if (m_rl || m_st) begin
        m_cnt = m_init; m_stage = 0;
      end else if (m_tk) begin
        if (m_cnt == 0) begin m_cnt = m_init; m_stage = 1 - m_stage; end
        else m_cnt = m_cnt - 1;
      end
      if (m_e1) m_s1 = 1;
      else if (wr_en_i && addr_i == 2'd2 && be_i[0] && wdata_i[3]) m_s1 = 0;
      if (m_e2) m_s2 = 1;
      else if (wr_en_i && addr_i == 2'd2 && be_i[2] && wdata_i[17]) m_s2 = 0;
      if (wr_en_i && addr_i == 2'd1) begin
        m_nv[9:8] = be_i[1] ? wdata_i[9:8] : 2'(m_init >> 8);
        m_nv[7:0] = be_i[0] ? wdata_i[7:0] : 8'(m_init);
        if (m_nv >= 10'd4) m_init = int'(m_nv);
      end
      if (wr_en_i && addr_i == 2'd3 && be_i[0]) begin
        m_en = int'(wdata_i[0]); m_nr = int'(wdata_i[4]);
      end
      if (nr_lock_i) m_nr = 1;
    end
  end

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return 32'(m_cnt);
      2'd1: return 32'(m_init);
      2'd2: return (32'(m_s1) << 3) | (32'(m_s2) << 17);
      default: return 32'(m_en) | (32'(m_nr) << 4);
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] a);
    case (a)
      2'd0: return "R6 model counter";
      2'd1: return "R3 model start value";
      2'd2: return "R9 model status";
      default: return "R10 model control";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_ni) begin
      chk(tag_of(addr_i), rdata_o, m_read(addr_i));
      chk("R8 model reset request", 32'(rst_req_o), 32'(m_req));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] b);
    @(posedge clk); #2;
    wr_en_i = 1'b1; addr_i = a; wdata_i = d; be_i = b;
    @(posedge clk); #2;
    wr_en_i = 1'b0; be_i = '0; wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    #2; addr_i = a;
    @(negedge clk);
    chk(tag, rdata_o, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_bit(input logic [1:0] a, input logic [31:0] m, output bit hit);
    hit = 1'b0;
    #2; addr_i = a;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if ((rdata_o & m) != 0) begin hit = 1'b1; break; end
    end
  endtask

  task automatic wait_req(output bit hit);
    hit = 1'b0;
    #2; addr_i = 2'd2;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (rst_req_o) begin hit = 1'b1; break; end
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    bit hit;
    int reqs;
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;

    // R1 reset state
    rd(2'd0, 32'(IR), "R1 counter after reset");
    rd(2'd1, 32'(IR), "R1 start value after reset");
    rd(2'd2, 32'h0, "R1 status after reset");
    rd(2'd3, 32'h0, "R1 control after reset");
    chk("R1 reset request low", 32'(rst_req_o), 32'h0);

    // R3 / R4 start value writes
    wr(2'd1, 32'h0000_FC0A, 4'b0011);
    rd(2'd1, 32'h0000_000A, "R3 only bits 9:0 stored");
    wr(2'd1, 32'h3, 4'b0011);
    rd(2'd1, 32'h0000_000A, "R4 value 3 ignored");
    wr(2'd1, 32'h0, 4'b0011);
    rd(2'd1, 32'h0000_000A, "R4 value 0 ignored");
    wr(2'd1, 32'h2, 4'b0001);
    rd(2'd1, 32'h0000_000A, "R4 merged value 2 ignored");
    wr(2'd1, 32'h3FF, 4'b0011);
    wr(2'd1, 32'h0C, 4'b0001);
    rd(2'd1, 32'h0000_030C, "R3 lane 0 only");
    wr(2'd1, 32'h6, 4'b0011);
    rd(2'd0, 32'(IR), "R3 start write leaves counter");

    // R5 / R6 reload key
    wr(2'd0, 32'h5, 4'b0001);
    rd(2'd0, 32'(IR), "R5 non-key value ignored");
    wr(2'd0, 32'h1, 4'b0001);
    rd(2'd0, 32'h6, "R5 R6 key loads counter");

    // R12 enable load, R2 new period
    tick_mode_i = 1'b1;
    wr(2'd3, 32'h1, 4'b0001);
    rd(2'd0, 32'h6, "R12 enable loads counter");
    wait_cyc(5);
    rd(2'd0, 32'h5, "R2 new period tick");

    // R12 halt
    wr(2'd3, 32'h0, 4'b0001);
    rd(2'd0, 32'h5, "R12 halted value");
    wait_cyc(20);
    rd(2'd0, 32'h5, "R12 counter holds while halted");

    // R2 legacy period
    tick_mode_i = 1'b0;
    wr(2'd3, 32'h1, 4'b0001);
    rd(2'd0, 32'h6, "R12 re-enable loads counter");
    wait_cyc(3);
    rd(2'd0, 32'h5, "R2 legacy period tick");

    // R7 first expiry
    wait_bit(2'd2, 32'h8, hit);
    chk("R7 first flag seen", 32'(hit), 32'h1);
    chk("R7 no reset on first expiry", 32'(rst_req_o), 32'h0);
    rd(2'd0, 32'h6, "R7 counter reloaded");

    // R8 second expiry
    wait_req(hit);
    chk("R8 reset request seen", 32'(hit), 32'h1);
    chk("R8 both flags set", rdata_o, 32'h0002_0008);
    #2 addr_i = 2'd0;
    @(negedge clk);
    chk("R8 request is one cycle", 32'(rst_req_o), 32'h0);
    chk("R8 counter reloaded", rdata_o, 32'h6);

    // R9 write-one-to-clear
    wr(2'd2, 32'h8, 4'b0001);
    rd(2'd2, 32'h0002_0000, "R9 clear bit 3 only");
    wr(2'd2, 32'h0002_0000, 4'b0011);
    rd(2'd2, 32'h0002_0000, "R9 lane 2 disabled keeps bit 17");
    wr(2'd2, 32'h0, 4'b1111);
    rd(2'd2, 32'h0002_0000, "R9 zeros keep bit 17");
    wait_req(hit);
    chk("R8 second round request", 32'(hit), 32'h1);
    wr(2'd2, 32'h0002_0008, 4'b1111);
    rd(2'd2, 32'h0, "R9 single write clears both");

    // R10 no-reboot gating
    wr(2'd3, 32'h11, 4'b0001);
    reqs = 0; hit = 1'b0;
    #2 addr_i = 2'd2;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (rst_req_o) reqs++;
      if (rdata_o[17]) begin hit = 1'b1; break; end
    end
    chk("R10 second flag set with no-reboot", 32'(hit), 32'h1);
    @(negedge clk);
    if (rst_req_o) reqs++;
    chk("R10 reset suppressed", 32'(reqs), 32'h0);

    // R11 lock
    #2 nr_lock_i = 1'b1;
    wr(2'd3, 32'h1, 4'b0001);
    nr_lock_i = 1'b0;
    rd(2'd3, 32'h11, "R11 locked bit reads 1");
    wr(2'd3, 32'h1, 4'b0001);
    rd(2'd3, 32'h1, "R10 bit clears after lock release");

    // R13 reload coincides with expiring tick
    wr(2'd0, 32'h1, 4'b0001);
    wr(2'd2, 32'h0002_0008, 4'b1111);
    rd(2'd2, 32'h0, "R13 status cleared before");
    wait_bit(2'd0, 32'hFFFF_FFFF, hit);
    #2 addr_i = 2'd0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (rdata_o == 32'h1) break;
    end
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (rdata_o == 32'h0) break;
    end
    chk("R13 counter reached zero", rdata_o, 32'h0);
    repeat (2) @(posedge clk);
    #2;
    wr_en_i = 1'b1; addr_i = 2'd0; wdata_i = 32'h1; be_i = 4'b0001;
    @(posedge clk); #2;
    wr_en_i = 1'b0; be_i = '0; wdata_i = '0;
    rd(2'd0, 32'h6, "R13 reload wins counter");
    rd(2'd2, 32'h0, "R13 no flag on coincident reload");
    chk("R13 no reset request", 32'(rst_req_o), 32'h0);

    wait_cyc(4);
    finish_run();
  end
endmodule